// File: doc/BRIEF.md
# Memory Write Lane Mapper with Repeat

This block sits between a 32/64-bit CPU-side write port and a 64-bit memory bus. A small mode register holds three flags: upper-half, extra-bit and repeat. It also holds a 7-bit repeat count. Each flag has its own set bit and its own clear bit. The register also carries a strobe that clears the display-processor interrupt.

Every write request brings a byte offset inside the 64-bit doubleword, a size (32 or 64 bit) and data. The block turns each request into one or more bus beats. Each beat carries the 64-bit word, a byte mask and the total beat count of the transfer. The byte at offset k of the doubleword travels on `bus_data[63-8k -: 8]`, and mask bit `7-k` enables it, so the bus is big-endian.

In repeat mode one 64-bit pattern is replayed over up to 16 beats (128 bytes). The first beat and the last beat are trimmed by the offset and the low count bits. Repeat mode clears itself once that transfer is done.

A two-state sequencer drives the beats:
- **IDLE**: `req_ready` is high. The transition IDLE→BURST happens on a request accept (`req_valid` while idle).
- **BURST**: `bus_valid` is high. BURST→BURST covers a stalled beat and a non-final beat that is accepted. BURST→IDLE happens when the final beat is accepted.

Top module: `wlane_mapper`

## Requirements
- R1: After reset, `cfg_rdata` is 0, `req_ready` is 1, `bus_valid` is 0 and `dp_irq_clr` is 0.
- R2: On a `cfg_wdata` write, each flag follows its own pair of bits: upper (set bit 13, clear bit 12), extra (set bit 10, clear bit 9) and repeat (set bit 8, clear bit 7). A 1 on set alone sets the flag and a 1 on clear alone clears it. Two 0s or two 1s leave the flag unchanged.
- R3: `cfg_rdata` returns upper on bit 9, extra on bit 8, repeat on bit 7 and the count on bits 6:0. All other bits read 0.
- R4: Every register write loads `cfg_wdata[6:0]` into the repeat count.
- R5: A register write with bit 11 set raises `dp_irq_clr` for exactly the one cycle after the write edge.
- R6: In normal mode (upper and repeat both 0), a 32-bit write goes to bytes 0..3 (`bus_data[63:32]`, mask 8'hF0) when `req_addr[2]` is 0, and to bytes 4..7 (mask 8'h0F) when it is 1. The other half is 0. A 64-bit write passes through unchanged with mask 8'hFF. Each such transfer is one beat.
- R7: With upper set and repeat clear, a 32-bit write always goes to bytes 0..3 with mask 8'hF0, whatever `req_addr[2]` is.
- R8: With repeat set, the pattern is the 64-bit data for a 64-bit write. For a 32-bit write the pattern is `{data[31:0], data[31:0]}`.
- R9: A repeat transfer has `count[6:3]+1` beats. Every beat carries the same pattern, and `bus_beats` reports the beat count on every beat.
- R10: In a repeat transfer, the first beat enables offsets k >= `req_addr[2:0]`. The last beat enables offsets k <= e, where e = (`req_addr[2:0]` + `count[2:0]`) mod 8, so the carry is dropped. Middle beats enable all bytes. A single beat applies both limits.
- R11: The repeat flag reads 0 after the final beat of a repeat transfer, and the next request maps as in R6/R7.
- R12: Requests are accepted only in IDLE, and the first beat appears the cycle after acceptance. `req_ready` stays 0 until the final beat is taken. While `bus_ready` is 0, `bus_valid`, `bus_data` and `bus_mask` hold.
- R13: A 32-bit transfer accepted with extra set drives `bus_extra_en`=1 and `bus_extra`=`data[3:0]` on its beats. Otherwise `bus_extra_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 32 | Mode register write word (set/clear layout) |
| cfg_rdata | output | 32 | Mode register read value |
| dp_irq_clr | output | 1 | One-cycle display-processor interrupt clear |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | 3 | Byte offset within the 64-bit doubleword |
| req_dw | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| req_data | input | 64 | Write data (32-bit writes use bits 31:0) |
| bus_valid | output | 1 | Bus beat valid |
| bus_ready | input | 1 | Bus beat taken |
| bus_data | output | 64 | Bus word |
| bus_mask | output | 8 | Byte enables, bit 7-k for offset k |
| bus_beats | output | 5 | Total beats of the current transfer |
| bus_last | output | 1 | Current beat is the final one |
| bus_extra_en | output | 1 | Extra-bit lanes valid |
| bus_extra | output | 4 | Extra-bit lane values |

## Verification
A register write takes effect at its clock edge. The bench drives at the falling edge and reads `cfg_rdata` and `dp_irq_clr` at the next falling edge, which is half a cycle after the update. The pulse is checked low again one cycle later.

A request is accepted at the first rising edge that sees it, and beat 0 is sampled at the following falling edge. Each later beat is sampled one cycle after the previous one, plus one cycle for every injected stall; during the stall the bench checks that the outputs hold. One cycle after the last beat, the bench checks that the bus is idle and that the repeat flag has dropped. The repeat sweep covers every count and every offset, and its expected masks come from shift arithmetic.

// File: rtl/wlm_pkg.sv
package wlm_pkg;
    localparam int unsigned BUS_W   = 64;
    localparam int unsigned LANES   = BUS_W / 8;
    localparam int unsigned OFF_W   = $clog2(LANES);
    localparam int unsigned CNT_W   = 7;
    localparam int unsigned BEAT_W  = CNT_W - OFF_W + 1;
    localparam int unsigned CFG_W   = 32;

    // register write bit positions
    localparam int unsigned WB_SET_UP  = 13;
    localparam int unsigned WB_CLR_UP  = 12;
    localparam int unsigned WB_CLR_DP  = 11;
    localparam int unsigned WB_SET_EX  = 10;
    localparam int unsigned WB_CLR_EX  = 9;
    localparam int unsigned WB_SET_RP  = 8;
    localparam int unsigned WB_CLR_RP  = 7;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } wlm_state_e;

    function automatic logic set_clr(input logic cur, input logic s, input logic c);
        if (s && !c)
            return 1'b1;
        else if (c && !s)
            return 1'b0;
        else
            return cur;
    endfunction
endpackage

// File: rtl/wlm_mode_reg.sv
module wlm_mode_reg
    import wlm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             rpt_done,
    output logic             upper_q,
    output logic             extra_q,
    output logic             rpt_q,
    output logic [CNT_W-1:0] count_q,
    output logic             dp_clr_q
);
    logic rpt_base;
    logic upper_d, extra_d, rpt_d;
    logic unused_hi;

    assign unused_hi = ^cfg_wdata[CFG_W-1:WB_SET_UP+1];

    always_comb begin
        rpt_base = rpt_done ? 1'b0 : rpt_q;
        upper_d  = upper_q;
        extra_d  = extra_q;
        rpt_d    = rpt_base;
        if (cfg_we) begin
            upper_d = set_clr(upper_q,  cfg_wdata[WB_SET_UP], cfg_wdata[WB_CLR_UP]);
            extra_d = set_clr(extra_q,  cfg_wdata[WB_SET_EX], cfg_wdata[WB_CLR_EX]);
            rpt_d   = set_clr(rpt_base, cfg_wdata[WB_SET_RP], cfg_wdata[WB_CLR_RP]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q  <= 1'b0;
            extra_q  <= 1'b0;
            rpt_q    <= 1'b0;
            count_q  <= '0;
            dp_clr_q <= 1'b0;
        end else begin
            upper_q  <= upper_d;
            extra_q  <= extra_d;
            rpt_q    <= rpt_d;
            dp_clr_q <= cfg_we & cfg_wdata[WB_CLR_DP];
            if (cfg_we)
                count_q <= cfg_wdata[CNT_W-1:0];
        end
    end

    // R2
    upper_pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[WB_SET_UP] && cfg_wdata[WB_CLR_UP]) |=> $stable(upper_q));
    // R2
    extra_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[WB_SET_EX] && !cfg_wdata[WB_CLR_EX]) |=> extra_q);
    // R11
    rpt_autoclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_done && !cfg_we) |=> !rpt_q);
    // R5
    dp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_clr_q |=> !dp_clr_q || $past(cfg_we));
endmodule

// File: rtl/wlm_lane_map.sv
module wlm_lane_map
    import wlm_pkg::*;
(
    input  logic [OFF_W-1:0]  addr,
    input  logic              dw,
    input  logic [BUS_W-1:0]  data,
    input  logic              upper,
    input  logic              rpt,
    input  logic [CNT_W-1:0]  count,
    output logic [BUS_W-1:0]  pattern,
    output logic [LANES-1:0]  first_mask,
    output logic [LANES-1:0]  last_mask,
    output logic [BEAT_W-1:0] beats
);
    localparam int unsigned HALF = BUS_W / 2;

    logic [OFF_W-1:0] end_off;
    logic [LANES-1:0] rp_first, rp_last;
    logic             lower_half;

    assign end_off = addr + count[OFF_W-1:0];

    // lane k (mask bit LANES-1-k) compared against the offsets
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign rp_first[LANES-1-k] = (k >= int'(addr));
        assign rp_last[LANES-1-k]  = (k <= int'(end_off));
    end

    assign lower_half = addr[OFF_W-1] & ~upper;

    always_comb begin
        if (rpt) begin
            pattern    = dw ? data : {data[HALF-1:0], data[HALF-1:0]};
            first_mask = rp_first;
            last_mask  = rp_last;
            beats      = BEAT_W'(count[CNT_W-1:OFF_W]) + BEAT_W'(1);
        end else if (dw) begin
            pattern    = data;
            first_mask = '1;
            last_mask  = '1;
            beats      = BEAT_W'(1);
        end else begin
            pattern    = lower_half ? {{HALF{1'b0}}, data[HALF-1:0]}
                                    : {data[HALF-1:0], {HALF{1'b0}}};
            first_mask = lower_half ? {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}}
                                    : {{(LANES/2){1'b1}}, {(LANES/2){1'b0}}};
            last_mask  = '1;
            beats      = BEAT_W'(1);
        end
    end
endmodule

// File: rtl/wlm_beat_fsm.sv
module wlm_beat_fsm
    import wlm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BUS_W-1:0]  ld_pattern,
    input  logic [LANES-1:0]  ld_first,
    input  logic [LANES-1:0]  ld_last,
    input  logic [BEAT_W-1:0] ld_beats,
    input  logic              ld_rpt,
    input  logic              ld_ext_en,
    input  logic [3:0]        ld_ext,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic [BUS_W-1:0]  bus_data,
    output logic [LANES-1:0]  bus_mask,
    output logic [BEAT_W-1:0] bus_beats,
    output logic              bus_last,
    output logic              bus_extra_en,
    output logic [3:0]        bus_extra,
    output logic              rpt_done
);
    wlm_state_e        state_q, state_d;
    logic [BEAT_W-1:0] beat_q, beats_q;
    logic [BUS_W-1:0]  pat_q;
    logic [LANES-1:0]  first_q, last_q;
    logic              rpt_q, ext_en_q;
    logic [3:0]        ext_q;
    logic              accept, fire, at_last;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign fire    = (state_q == ST_BURST) && bus_ready;
    assign at_last = (beat_q == beats_q - BEAT_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_BURST;
            ST_BURST: if (fire && at_last) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // transfer descriptor and beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q   <= '0;
            beats_q  <= BEAT_W'(1);
            pat_q    <= '0;
            first_q  <= '0;
            last_q   <= '0;
            rpt_q    <= 1'b0;
            ext_en_q <= 1'b0;
            ext_q    <= '0;
        end else if (accept) begin
            beat_q   <= '0;
            beats_q  <= ld_beats;
            pat_q    <= ld_pattern;
            first_q  <= ld_first;
            last_q   <= ld_last;
            rpt_q    <= ld_rpt;
            ext_en_q <= ld_ext_en;
            ext_q    <= ld_ext;
        end else if (fire && !at_last) begin
            beat_q <= beat_q + BEAT_W'(1);
        end
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        bus_valid    = 1'b0;
        bus_mask     = '0;
        rpt_done     = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_BURST: begin
                bus_valid = 1'b1;
                bus_mask  = (beat_q == '0 ? first_q : {LANES{1'b1}})
                          & (at_last ? last_q : {LANES{1'b1}});
                rpt_done  = bus_ready & at_last & rpt_q;
            end
            default: ;
        endcase
        bus_data     = pat_q;
        bus_beats    = beats_q;
        bus_last     = bus_valid & at_last;
        bus_extra_en = bus_valid & ext_en_q;
        bus_extra    = ext_q;
    end

    // R12
    ready_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && bus_valid));
    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_data) && $stable(bus_mask)));
    // R9
    beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (beat_q < bus_beats));
    // R12
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bus_valid && beat_q == '0));
endmodule

// File: rtl/wlane_mapper.sv
module wlane_mapper
    import wlm_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [31:0]  cfg_wdata,
    output logic [31:0]  cfg_rdata,
    output logic         dp_irq_clr,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [2:0]   req_addr,
    input  logic         req_dw,
    input  logic [63:0]  req_data,
    output logic         bus_valid,
    input  logic         bus_ready,
    output logic [63:0]  bus_data,
    output logic [7:0]   bus_mask,
    output logic [4:0]   bus_beats,
    output logic         bus_last,
    output logic         bus_extra_en,
    output logic [3:0]   bus_extra
);
    logic             upper_q, extra_q, rpt_q, rpt_done;
    logic [CNT_W-1:0] count_q;
    logic [BUS_W-1:0] map_pattern;
    logic [LANES-1:0] map_first, map_last;
    logic [BEAT_W-1:0] map_beats;

    wlm_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .rpt_done (rpt_done),
        .upper_q  (upper_q),
        .extra_q  (extra_q),
        .rpt_q    (rpt_q),
        .count_q  (count_q),
        .dp_clr_q (dp_irq_clr)
    );

    assign cfg_rdata = {{(CFG_W-CNT_W-3){1'b0}}, upper_q, extra_q, rpt_q, count_q};

    wlm_lane_map u_map (
        .addr      (req_addr),
        .dw        (req_dw),
        .data      (req_data),
        .upper     (upper_q),
        .rpt       (rpt_q),
        .count     (count_q),
        .pattern   (map_pattern),
        .first_mask(map_first),
        .last_mask (map_last),
        .beats     (map_beats)
    );

    wlm_beat_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .ld_pattern  (map_pattern),
        .ld_first    (map_first),
        .ld_last     (map_last),
        .ld_beats    (map_beats),
        .ld_rpt      (rpt_q),
        .ld_ext_en   (extra_q & ~req_dw),
        .ld_ext      (req_data[3:0]),
        .bus_valid   (bus_valid),
        .bus_ready   (bus_ready),
        .bus_data    (bus_data),
        .bus_mask    (bus_mask),
        .bus_beats   (bus_beats),
        .bus_last    (bus_last),
        .bus_extra_en(bus_extra_en),
        .bus_extra   (bus_extra),
        .rpt_done    (rpt_done)
    );
endmodule

// File: tb/wlane_mapper_tb.sv
module wlane_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        dp_irq_clr;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_addr = '0;
    logic        req_dw = 1'b0;
    logic [63:0] req_data = '0;
    logic        bus_valid;
    logic        bus_ready = 1'b1;
    logic [63:0] bus_data;
    logic [7:0]  bus_mask;
    logic [4:0]  bus_beats;
    logic        bus_last;
    logic        bus_extra_en;
    logic [3:0]  bus_extra;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    wlane_mapper u_dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic xfer(input string tag, input logic [2:0] a, input logic dw,
                        input logic [63:0] d, input bit stall, input int nb,
                        input logic [63:0] pat, input logic [7:0] fm, input logic [7:0] lm,
                        input logic ext_en, input logic [3:0] ext);
        @(negedge clk);
        chk({tag, " R12 ready idle"}, req_ready, 1);
        req_valid = 1'b1;
        req_addr  = a;
        req_dw    = dw;
        req_data  = d;
        @(negedge clk);
        req_valid = 1'b0;
        for (int b = 0; b < nb; b++) begin
            logic [7:0] em;
            em = (b == 0 ? fm : 8'hFF) & (b == nb - 1 ? lm : 8'hFF);
            chk({tag, " R12 valid"}, bus_valid, 1);
            chk({tag, " R12 ready low"}, req_ready, 0);
            chk({tag, " data"}, bus_data, pat);
            chk({tag, " mask"}, bus_mask, em);
            chk({tag, " R9 beats"}, bus_beats, nb);
            chk({tag, " last"}, bus_last, (b == nb - 1));
            chk({tag, " R13 ext_en"}, bus_extra_en, ext_en);
            if (ext_en) chk({tag, " R13 ext"}, bus_extra, ext);
            if (stall && b == 0) begin
                bus_ready = 1'b0;
                @(negedge clk);
                chk({tag, " R12 stall valid"}, bus_valid, 1);
                chk({tag, " R12 stall data"}, bus_data, pat);
                chk({tag, " R12 stall mask"}, bus_mask, em);
                bus_ready = 1'b1;
            end
            @(negedge clk);
        end
        chk({tag, " R12 idle after"}, bus_valid, 0);
        chk({tag, " R12 ready after"}, req_ready, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic m_up, m_ex, m_rp;
        logic [6:0] m_cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 rdata", cfg_rdata, 0);
        chk("R1 ready", req_ready, 1);
        chk("R1 valid", bus_valid, 0);
        chk("R1 dp", dp_irq_clr, 0);

        // R2 R3 R4: sweep all set/clear combinations
        m_up = 0; m_ex = 0; m_rp = 0; m_cnt = 0;
        for (int i = 0; i < 64; i++) begin
            logic [31:0] w;
            logic [6:0] c;
            c = 7'((i * 37) & 127);
            w = 32'(c);
            w[13] = i[0]; w[12] = i[1];
            w[10] = i[2]; w[9]  = i[3];
            w[8]  = i[4]; w[7]  = i[5];
            cfg_write(w);
            if (i[0] && !i[1]) m_up = 1; else if (i[1] && !i[0]) m_up = 0;
            if (i[2] && !i[3]) m_ex = 1; else if (i[3] && !i[2]) m_ex = 0;
            if (i[4] && !i[5]) m_rp = 1; else if (i[5] && !i[4]) m_rp = 0;
            m_cnt = c;
            chk("R2 R3 R4 readback", cfg_rdata, {22'b0, m_up, m_ex, m_rp, m_cnt});
        end
        cfg_write(32'h0000_1280);
        chk("R2 cleared", cfg_rdata, 0);

        // R5
        cfg_write(32'h0000_0800);
        chk("R5 pulse", dp_irq_clr, 1);
        @(negedge clk);
        chk("R5 pulse ends", dp_irq_clr, 0);

        // R6 normal, R7 upper
        for (int u = 0; u < 2; u++) begin
            if (u == 1) cfg_write(32'h0000_2000);
            for (int a = 0; a < 8; a++) begin
                logic [63:0] d;
                logic [63:0] ep;
                bit lo;
                d  = 64'h1122_3344_0000_0000 | 64'(32'hA0B0_C0D0 + 32'(a));
                lo = (a >= 4) && (u == 0);
                ep = lo ? {32'h0, d[31:0]} : {d[31:0], 32'h0};
                xfer(u ? "R7 upper 32" : "R6 normal 32", 3'(a), 1'b0, d, a == 5, 1,
                     ep, lo ? 8'h0F : 8'hF0, 8'hFF, 1'b0, 4'h0);
                xfer(u ? "R7 upper 64" : "R6 normal 64", 3'(a), 1'b1, d, 0, 1,
                     d, 8'hFF, 8'hFF, 1'b0, 4'h0);
            end
        end
        cfg_write(32'h0000_1000);

        // R13 extra mode
        cfg_write(32'h0000_0400);
        xfer("R13 extra", 3'd4, 1'b0, 64'h0000_0000_1234_567B, 0, 1,
             64'h0000_0000_1234_567B, 8'h0F, 8'hFF, 1'b1, 4'hB);
        cfg_write(32'h0000_0200);

        // R8 R9 R10 R11 repeat sweep
        for (int c = 0; c < 128; c++) begin
            for (int a = 0; a < 8; a++) begin
                logic [63:0] d, ep;
                bit dw;
                int nb, e;
                d  = {8{8'(c)}} ^ {8'(a), 56'h13_5724_68AC_E0F1};
                dw = ((c + a) & 1) == 1;
                ep = dw ? d : {d[31:0], d[31:0]};
                nb = (c >> 3) + 1;
                e  = (a + (c & 7)) & 7;
                cfg_write(32'h0000_0100 | 32'(c));
                xfer("R8 R9 R10 repeat", 3'(a), dw, d, a == 3, nb,
                     ep, 8'hFF >> a, 8'(8'hFF << (7 - e)), 1'b0, 4'h0);
                chk("R11 repeat cleared", cfg_rdata[7], 0);
            end
        end
        // R11 next request maps normally
        xfer("R11 normal after repeat", 3'd6, 1'b0, 64'h0000_0000_CAFE_F00D, 0, 1,
             64'h0000_0000_CAFE_F00D, 8'h0F, 8'hFF, 1'b0, 4'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule